// File: doc/BRIEF.md
# Nibble Arithmetic Unit with Carry and Zero Flags

This block is the arithmetic core of a small accumulator machine. Each cycle it takes the accumulator value, an operand that logic outside the block has already selected, and a three-bit operation code. In the same cycle it returns the result word and a write enable for the accumulator. It also returns, for each flag, the value that flag will hold after the next clock edge and a matching update enable.

The only logic primitive is NAND. Addition reports a true carry out of the top bit. Subtraction and compare report a borrow in the same flag. The zero flag follows every operation that writes the accumulator, including plain loads, and it also follows compare. Operations that write no accumulator leave both flags untouched. The two flags sit in registers inside the block, update only on an enabled clock edge, and clear on reset.

Top module: `alu4_flags`

## Requirements
- R1: Code 3'd2 (NAND) gives result = ~(acc & operand), asserts the accumulator write enable and the zero-flag enable, and leaves the carry flag unchanged.
- R2: Code 3'd3 (ADD) gives result = (acc + operand) mod 2^WIDTH, and the carry flag becomes the carry out of the top bit.
- R3: Code 3'd4 (SUB) gives result = (acc - operand) mod 2^WIDTH, writes the accumulator, and the carry flag becomes 1 exactly when operand > acc as unsigned values.
- R4: Code 3'd5 (CMP) does not assert the accumulator write enable. Carry becomes the borrow of acc - operand, and zero becomes 1 exactly when acc equals operand. The result output carries the difference.
- R5: For every code that writes the accumulator, the zero flag becomes 1 exactly when the result is zero.
- R6: Code 3'd1 (LOAD) passes the operand to the result, writes the accumulator, updates the zero flag and holds the carry flag.
- R7: Codes 3'd0, 3'd6 and 3'd7 (no-flag operations, such as register writes, output and store) assert no enable, and both flags keep their values.
- R8: The flag registers take the value of the next-flag outputs on each clock edge. When a flag's enable is low, its next-flag output equals its current registered value.
- R9: Reset (rst_n low) clears both flags to 0.
- R10: Adding 0xF to 0x1 gives result 0 with both the carry and zero flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| acc_i | input | WIDTH | Current accumulator value |
| opnd_i | input | WIDTH | Selected operand |
| result_o | output | WIDTH | Combinational result |
| acc_we_o | output | 1 | The accumulator should take result_o |
| cf_we_o | output | 1 | The carry flag updates this cycle |
| zf_we_o | output | 1 | The zero flag updates this cycle |
| cf_next_o | output | 1 | Carry flag value after the next edge |
| zf_next_o | output | 1 | Zero flag value after the next edge |
| cf_o | output | 1 | Registered carry flag |
| zf_o | output | 1 | Registered zero flag |

## Verification
The bench builds the block with the default WIDTH of 4. This keeps the whole space of 16 x 16 operand pairs for each of the eight codes small enough for random stimulus to reach every borrow, carry and zero boundary many times over. Directed cases pin down the wrap from 0xF + 1, the borrow on 0 - 1, an equal compare, and NAND of all ones. A reference flag model in the bench carries state across cycles, so any flag that changes when its enable is low shows up as a mismatch.

// File: rtl/alu4_flags.sv
module alu4_flags #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] opnd_i,
  output logic [WIDTH-1:0] result_o,
  output logic             acc_we_o,
  output logic             cf_we_o,
  output logic             zf_we_o,
  output logic             cf_next_o,
  output logic             zf_next_o,
  output logic             cf_o,
  output logic             zf_o
);
  localparam logic [2:0] OP_LOAD = 3'd1;
  localparam logic [2:0] OP_NAND = 3'd2;
  localparam logic [2:0] OP_ADD  = 3'd3;
  localparam logic [2:0] OP_SUB  = 3'd4;
  localparam logic [2:0] OP_CMP  = 3'd5;

  logic [WIDTH:0] sum_w, diff_w;
  logic           carry_w;

  assign sum_w  = {1'b0, acc_i} + {1'b0, opnd_i};
  assign diff_w = {1'b0, acc_i} - {1'b0, opnd_i};

  always_comb begin
    result_o = acc_i;
    acc_we_o = 1'b0;
    cf_we_o  = 1'b0;
    zf_we_o  = 1'b0;
    carry_w  = 1'b0;
    case (op_i)
      OP_LOAD: begin result_o = opnd_i; acc_we_o = 1'b1; zf_we_o = 1'b1; end
      OP_NAND: begin result_o = ~(acc_i & opnd_i); acc_we_o = 1'b1; zf_we_o = 1'b1; end
      OP_ADD: begin
        result_o = sum_w[WIDTH-1:0]; carry_w = sum_w[WIDTH];
        acc_we_o = 1'b1; cf_we_o = 1'b1; zf_we_o = 1'b1;
      end
      OP_SUB: begin
        result_o = diff_w[WIDTH-1:0]; carry_w = diff_w[WIDTH];
        acc_we_o = 1'b1; cf_we_o = 1'b1; zf_we_o = 1'b1;
      end
      OP_CMP: begin
        result_o = diff_w[WIDTH-1:0]; carry_w = diff_w[WIDTH];
        cf_we_o = 1'b1; zf_we_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign cf_next_o = cf_we_o ? carry_w : cf_o;
  assign zf_next_o = zf_we_o ? (result_o == '0) : zf_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf_o <= 1'b0;
      zf_o <= 1'b0;
    end else begin
      cf_o <= cf_next_o;
      zf_o <= zf_next_o;
    end
  end

  // R8
  cf_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cf_o == $past(cf_next_o));
  // R8
  zf_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> zf_o == $past(zf_next_o));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cf_we_o && !zf_we_o) |=> ($stable(cf_o) && $stable(zf_o)));
  // R5
  acc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we_o |-> (zf_we_o && zf_next_o == (result_o == '0)));
  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_ADD) |-> ({cf_next_o, result_o} == (WIDTH+1)'(acc_i) + (WIDTH+1)'(opnd_i)));
  // R4
  cmp_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> (!acc_we_o && cf_next_o == (opnd_i > acc_i) && zf_next_o == (opnd_i == acc_i)));
endmodule

// File: tb/alu4_flags_tb_top.sv
module alu4_flags_tb_top;
  localparam int W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [W-1:0] acc = '0, opnd = '0;
  logic [W-1:0] result;
  logic acc_we, cf_we, zf_we, cf_next, zf_next, cf, zf;
  int n_chk = 0, n_bad = 0;
  logic m_cf = 1'b0, m_zf = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  alu4_flags #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op), .acc_i(acc), .opnd_i(opnd),
    .result_o(result), .acc_we_o(acc_we), .cf_we_o(cf_we), .zf_we_o(zf_we),
    .cf_next_o(cf_next), .zf_next_o(zf_next), .cf_o(cf), .zf_o(zf));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_res(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    case (o)
      3'd1: return b;
      3'd2: return ~(a & b);
      3'd3: return a + b;
      3'd4, 3'd5: return a - b;
      default: return a;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] o);
    case (o)
      3'd1: return "R6";
      3'd2: return "R1";
      3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R4";
      default: return "R7";
    endcase
  endfunction

  task automatic step(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    logic awe, cwe, zwe, ncf, nzf;
    @(negedge clk);
    op = o; acc = a; opnd = b;
    #1;
    r   = exp_res(o, a, b);
    awe = (o >= 3'd1 && o <= 3'd4);
    cwe = (o >= 3'd3 && o <= 3'd5);
    zwe = (o >= 3'd1 && o <= 3'd5);
    ncf = m_cf;
    if (o == 3'd3) ncf = ({1'b0, a} + {1'b0, b}) > (2**W - 1);
    if (o == 3'd4 || o == 3'd5) ncf = b > a;
    nzf = zwe ? (r == 0) : m_zf;
    if (o != 3'd0 && o < 3'd6) chk(tag(o), result, r);
    chk({tag(o), " acc_we"}, acc_we, awe);
    chk({tag(o), " cf_we"}, cf_we, cwe);
    chk({tag(o), " zf_we"}, zf_we, zwe);
    chk({tag(o), " cf_next"}, cf_next, ncf);
    chk({tag(o), " R5 zf_next"}, zf_next, nzf);
    chk("R8 cf_o", cf, m_cf);
    chk("R8 zf_o", zf, m_zf);
    @(posedge clk);
    m_cf = ncf; m_zf = nzf;
  endtask

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #9;
    chk("R9 cf reset", cf, 0);
    chk("R9 zf reset", zf, 0);
    @(negedge clk); rst_n = 1'b1;
    // R10: 1 + F -> 0 with carry and zero
    step(3'd3, 4'h1, 4'hF);
    chk("R10 result", result, 0);
    @(negedge clk); #1;
    chk("R10 cf", cf, 1);
    chk("R10 zf", zf, 1);
    // R6: load keeps carry set, zero cleared by nonzero load
    step(3'd1, 4'h0, 4'h7);
    // R7: no-flag codes hold
    step(3'd0, 4'h0, 4'h0);
    step(3'd6, 4'h3, 4'h3);
    step(3'd7, 4'h0, 4'h0);
    // R3: borrow on 0 - 1
    step(3'd4, 4'h0, 4'h1);
    // R4: equal compare
    step(3'd5, 4'h9, 4'h9);
    // R1: NAND of all ones gives zero, carry held
    step(3'd2, 4'hF, 4'hF);
    // R6: load zero
    step(3'd1, 4'h5, 4'h0);
    // R2: no-carry boundary
    step(3'd3, 4'h7, 4'h8);
    for (int i = 0; i < 3000; i++)
      step(3'($urandom_range(0, 7)), W'($urandom), W'($urandom));
    // R9: reset in mid-run clears flags
    step(3'd3, 4'hF, 4'hF);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R9 cf reset again", cf, 0);
    chk("R9 zf reset again", zf, 0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule